// File: doc/BRIEF.md
# Multi-Format Audio Serial Port

This block is the slave side of a stereo audio serial link. A remote master supplies a bit clock and a frame clock. The block sends one stereo capture pair out on a serial output line and takes one stereo playback pair in from a serial input line. Four framing formats and four word lengths can be selected. Three modifiers are available: bit-clock edge inversion, frame-clock polarity inversion, and left/right exchange of the received playback pair.

The block runs on its own system clock. It over-samples the two serial clocks and the serial input through a short synchronizer and turns bit-clock transitions into single-cycle events. On the parallel side, a capture pair is written with a strobe, and each received playback pair is presented with a one-cycle valid pulse.

Position counting is done separately for the transmit and receive directions. Each direction counts bit-clock events since the last frame-clock boundary and maps that position onto a word bit. Right-justified placement needs the length of a half frame, so the block measures it from the previous half.

Top module: `audio_serial_port`

## Requirements
- R1: After reset the serial output, the valid strobe and both parallel playback words are 0.
- R2: Format code 2'b10 is I2S. The left word is carried while the frame clock is low. Its MSB is on the second bit clock after the frame-clock transition, and words go MSB first with the LSB last.
- R3: Format code 2'b01 is left-justified. The left word is carried while the frame clock is high, and its MSB is on the first bit clock of the half frame.
- R4: Format code 2'b00 is right-justified. Half-frame polarity is the same as in R3. The LSB is on the last bit clock of each half frame, and the half-frame length is measured from the preceding half.
- R5: Word-length code 00/01/10/11 selects 16/20/24/32 bits in every format.
- R6: Outside DSP format, a polarity input of 1 inverts the frame clock before it is interpreted.
- R7: Format code 2'b11 is DSP. A frame-clock pulse marks the frame, and the right word follows the left word with no gap. With the polarity input at 0 the left MSB is one bit clock after the pulse bit clock. With the polarity input at 1 it is on the pulse bit clock itself. The frame clock is never inverted in this format.
- R8: With bit-clock inversion at 0, the serial input and frame clock are sampled on the rising bit-clock edge and the serial output changes after the falling edge. With inversion at 1 the edges are exchanged. The serial output changes only at a launch edge.
- R9: With the swap input at 1, the word received in the left slot appears on the right playback port and the reverse.
- R10: Bit positions outside a word are driven as 0 on the serial output and ignored on the serial input. Capture-word bits at or above the word length are not sent.
- R11: A received pair appears right-aligned, with zeros above the word length. The valid strobe is high for one system cycle after the right-channel LSB is sampled, and it occurs once per frame.
- R12: The capture pair is stored on its strobe and starts to be sent at the next left-slot start. Without a strobe the stored pair is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Framing format code |
| wlen_i | input | 2 | Word-length code |
| lr_pol_i | input | 1 | Frame-clock inversion, or DSP submode select |
| bit_clk_inv_i | input | 1 | Exchanges the sample and launch bit-clock edges |
| swap_i | input | 1 | Exchanges received left and right words |
| bit_clk_i | input | 1 | Serial bit clock from the master |
| frame_clk_i | input | 1 | Serial frame clock from the master |
| ser_in_i | input | 1 | Serial playback data |
| ser_out_o | output | 1 | Serial capture data |
| cap_left_i | input | DATA_W | Capture word for the left channel, right-aligned |
| cap_right_i | input | DATA_W | Capture word for the right channel, right-aligned |
| cap_valid_i | input | 1 | Stores the capture pair |
| pb_left_o | output | DATA_W | Received left word |
| pb_right_o | output | DATA_W | Received right word |
| pb_valid_o | output | 1 | One-cycle strobe for a new received pair |

## Verification
The assertions assume that each bit-clock half period spans several system cycles, so that consecutive edge events never fall in adjacent cycles. They also assume that the frame clock and the serial input change only together with the launch edge. The bench keeps to this by holding each bit-clock phase for six system cycles and by changing the frame clock, serial input and bit clock only at the start of a launch phase. The half frame is 34 bit clocks long, so every word, including a 32-bit I2S or DSP frame with its one-bit offset, fits inside its frame. Each configuration runs for two warm-up frames before the checked frame.

// File: rtl/asp_pkg.sv
package asp_pkg;

   typedef enum logic [1:0] {
      FMT_RJ  = 2'b00,
      FMT_LJ  = 2'b01,
      FMT_I2S = 2'b10,
      FMT_DSP = 2'b11
   } asp_fmt_e;

   typedef logic [5:0] asp_wl_t;

   function automatic asp_wl_t asp_word_len(input logic [1:0] code);
      case (code)
         2'b00:   return 6'd16;
         2'b01:   return 6'd20;
         2'b10:   return 6'd24;
         default: return 6'd32;
      endcase
   endfunction

endpackage

// File: rtl/asp_pin_sync.sv
module asp_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_clk,
   input  logic frame_clk,
   input  logic ser_in,
   input  logic inv,
   output logic cap_ev,
   output logic launch_ev,
   output logic lr_s,
   output logic din_s
);
   logic [2:0] last_stage;
   logic       eff;
   logic       prev_q;

   generate
      if (STAGES == 1) begin : g_one
         logic [2:0] s;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s <= '0;
            else        s <= {bit_clk, frame_clk, ser_in};
         end
         assign last_stage = s;
      end else begin : g_many
         logic [STAGES-1:0][2:0] s;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s <= '0;
            else        s <= {s[STAGES-2:0], {bit_clk, frame_clk, ser_in}};
         end
         assign last_stage = s[STAGES-1];
      end
   endgenerate

   assign eff = last_stage[2] ^ inv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= eff;
   end

   assign cap_ev    = eff & ~prev_q;
   assign launch_ev = ~eff & prev_q;
   assign lr_s      = last_stage[1];
   assign din_s     = last_stage[0];

endmodule

// File: rtl/asp_slot_map.sv
module asp_slot_map
   import asp_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev,
   input  logic             lr,
   input  asp_fmt_e         fmt,
   input  asp_wl_t          wl,
   input  logic             sub2,
   output logic             act,
   output logic             ch,
   output logic             last,
   output logic             frame_start,
   output logic [IDX_W-1:0] bit_idx
);
   localparam int SW = CNT_W + 2;
   localparam logic [CNT_W-1:0]     POS_MAX = '1;
   localparam logic [CNT_W-1:0]     POS_ONE = CNT_W'(1);
   localparam logic signed [SW-1:0] ZERO = '0;
   localparam logic signed [SW-1:0] ONE  = SW'(1);

   logic             lr_d1, lr_d2, started_q, len_ok_q;
   logic [CNT_W-1:0] pos_q, len_q, pos_now;
   logic             is_i2s, is_dsp, cur_lr, boundary, in_word, right_part;
   logic signed [SW-1:0] wl_s, off, d, dl, span;

   always_comb begin
      is_i2s = (fmt == FMT_I2S);
      is_dsp = (fmt == FMT_DSP);
      cur_lr = is_i2s ? lr_d1 : lr;
      if (is_dsp)      boundary = lr & ~lr_d1;
      else if (is_i2s) boundary = lr_d1 ^ lr_d2;
      else             boundary = lr ^ lr_d1;
      pos_now = boundary ? '0 : ((pos_q == POS_MAX) ? pos_q : pos_q + POS_ONE);
      wl_s = $signed({{(SW-6){1'b0}}, wl});
      case (fmt)
         FMT_RJ:  off = $signed({2'b00, len_q}) - wl_s;
         FMT_DSP: off = sub2 ? ZERO : ONE;
         default: off = ZERO;
      endcase
      d          = $signed({2'b00, pos_now}) - off;
      span       = is_dsp ? (wl_s + wl_s) : wl_s;
      right_part = is_dsp && (d >= wl_s);
      dl         = right_part ? (d - wl_s) : d;
      in_word    = (d >= ZERO) && (d < span) && (started_q || boundary) &&
                   ((fmt != FMT_RJ) || len_ok_q);
      ch          = is_dsp ? right_part : (is_i2s ? cur_lr : ~cur_lr);
      act         = ev & in_word;
      last        = (dl == (wl_s - ONE));
      bit_idx     = IDX_W'(wl_s - ONE - dl);
      frame_start = ev & boundary & (is_dsp | (is_i2s ? ~cur_lr : cur_lr));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_d1     <= 1'b0;
         lr_d2     <= 1'b0;
         pos_q     <= '0;
         len_q     <= '0;
         started_q <= 1'b0;
         len_ok_q  <= 1'b0;
      end else if (ev) begin
         lr_d1 <= lr;
         lr_d2 <= lr_d1;
         pos_q <= pos_now;
         if (boundary) begin
            started_q <= 1'b1;
            if (started_q) begin
               len_q    <= pos_q + POS_ONE;
               len_ok_q <= 1'b1;
            end
         end
      end
   end

   // R5: a selected bit always lies inside the configured word
   p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> (int'(bit_idx) < int'(wl)));

endmodule

// File: rtl/asp_tx_ser.sv
module asp_tx_ser #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] cap_l,
   input  logic [DATA_W-1:0] cap_r,
   input  logic              cap_load,
   input  logic              ev,
   input  logic              act,
   input  logic              ch,
   input  logic              last,
   input  logic              frame_start,
   input  logic [IDX_W-1:0]  bit_idx,
   output logic              ser_out
);
   logic [DATA_W-1:0] hold_l, hold_r, shd_l, shd_r, src_l, src_r;

   always_comb begin
      src_l = frame_start ? hold_l : shd_l;
      src_r = frame_start ? hold_r : shd_r;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_l  <= '0;
         hold_r  <= '0;
         shd_l   <= '0;
         shd_r   <= '0;
         ser_out <= 1'b0;
      end else begin
         if (cap_load) begin
            hold_l <= cap_l;
            hold_r <= cap_r;
         end
         if (frame_start) begin
            shd_l <= hold_l;
            shd_r <= hold_r;
         end
         if (ev) ser_out <= act ? (ch ? src_r[bit_idx] : src_l[bit_idx]) : 1'b0;
      end
   end

   p_fill_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev && !act) |=> !ser_out);

   p_out_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ev |=> $stable(ser_out));

   p_lsb_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (act && last) |-> (bit_idx == '0));

endmodule

// File: rtl/asp_rx_deser.sv
module asp_rx_deser
   import asp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act,
   input  logic              ch,
   input  logic              last,
   input  logic              frame_start,
   input  logic [IDX_W-1:0]  bit_idx,
   input  logic              din,
   input  logic              swap,
   input  asp_wl_t           wl,
   output logic [DATA_W-1:0] pb_l,
   output logic [DATA_W-1:0] pb_r,
   output logic              pb_valid
);
   logic [DATA_W-2:0] sr;
   logic [DATA_W-1:0] word, mask, word_m, left_tmp;
   logic              have_left;

   always_comb begin
      word = {sr, din};
      for (int i = 0; i < DATA_W; i++) mask[i] = (i < int'(wl));
      word_m = word & mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr        <= '0;
         left_tmp  <= '0;
         have_left <= 1'b0;
         pb_l      <= '0;
         pb_r      <= '0;
         pb_valid  <= 1'b0;
      end else begin
         pb_valid <= 1'b0;
         if (frame_start) have_left <= 1'b0;
         if (act) begin
            sr <= word[DATA_W-2:0];
            if (last) begin
               if (!ch) begin
                  left_tmp  <= word_m;
                  have_left <= 1'b1;
               end else begin
                  pb_valid  <= have_left;
                  have_left <= 1'b0;
                  if (have_left) begin
                     pb_l <= swap ? word_m : left_tmp;
                     pb_r <= swap ? left_tmp : word_m;
                  end
               end
            end
         end
      end
   end

   p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pb_valid |=> !pb_valid);

   p_valid_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pb_valid |-> $past(act && last && ch));

   p_rx_lsb_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (act && last) |-> (bit_idx == '0));

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
   import asp_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        fmt_i,
   input  logic [1:0]        wlen_i,
   input  logic              lr_pol_i,
   input  logic              bit_clk_inv_i,
   input  logic              swap_i,
   input  logic              bit_clk_i,
   input  logic              frame_clk_i,
   input  logic              ser_in_i,
   output logic              ser_out_o,
   input  logic [DATA_W-1:0] cap_left_i,
   input  logic [DATA_W-1:0] cap_right_i,
   input  logic              cap_valid_i,
   output logic [DATA_W-1:0] pb_left_o,
   output logic [DATA_W-1:0] pb_right_o,
   output logic              pb_valid_o
);
   localparam int IDX_W = $clog2(DATA_W);

   generate
      if (DATA_W < 32) begin : g_bad_data_w
         $error("DATA_W must hold a 32-bit word");
      end
      if (CNT_W < 7) begin : g_bad_cnt_w
         $error("CNT_W must count a full two-word DSP frame");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least one");
      end
   endgenerate

   asp_fmt_e fmt;
   asp_wl_t  wl;
   logic     cap_ev, launch_ev, lr_s, din_s, lr_eff;
   logic     t_act, t_ch, t_last, t_fs;
   logic     r_act, r_ch, r_last, r_fs;
   logic [IDX_W-1:0] t_idx, r_idx;

   assign fmt    = asp_fmt_e'(fmt_i);
   assign wl     = asp_word_len(wlen_i);
   assign lr_eff = lr_s ^ (lr_pol_i & (fmt != FMT_DSP));

   asp_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk_i), .frame_clk(frame_clk_i),
      .ser_in(ser_in_i), .inv(bit_clk_inv_i), .cap_ev(cap_ev),
      .launch_ev(launch_ev), .lr_s(lr_s), .din_s(din_s));

   asp_slot_map #(.CNT_W(CNT_W), .IDX_W(IDX_W)) i_tx_map (
      .clk(clk), .rst_n(rst_n), .ev(launch_ev), .lr(lr_eff), .fmt(fmt),
      .wl(wl), .sub2(lr_pol_i), .act(t_act), .ch(t_ch), .last(t_last),
      .frame_start(t_fs), .bit_idx(t_idx));

   asp_slot_map #(.CNT_W(CNT_W), .IDX_W(IDX_W)) i_rx_map (
      .clk(clk), .rst_n(rst_n), .ev(cap_ev), .lr(lr_eff), .fmt(fmt),
      .wl(wl), .sub2(lr_pol_i), .act(r_act), .ch(r_ch), .last(r_last),
      .frame_start(r_fs), .bit_idx(r_idx));

   asp_tx_ser #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_tx (
      .clk(clk), .rst_n(rst_n), .cap_l(cap_left_i), .cap_r(cap_right_i),
      .cap_load(cap_valid_i), .ev(launch_ev), .act(t_act), .ch(t_ch),
      .last(t_last), .frame_start(t_fs), .bit_idx(t_idx), .ser_out(ser_out_o));

   asp_rx_deser #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_rx (
      .clk(clk), .rst_n(rst_n), .act(r_act), .ch(r_ch), .last(r_last),
      .frame_start(r_fs), .bit_idx(r_idx), .din(din_s), .swap(swap_i),
      .wl(wl), .pb_l(pb_left_o), .pb_r(pb_right_o), .pb_valid(pb_valid_o));

endmodule

// File: tb/test_audio_serial_port.sv
`timescale 1ns/1ps
module test_audio_serial_port;
   localparam int HALF = 6;
   localparam int S    = 34;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  fmt_i = 2'b10, wlen_i = 2'b10;
   logic        lr_pol_i = 1'b0, bit_clk_inv_i = 1'b0, swap_i = 1'b0;
   logic        bit_clk_i = 1'b0, frame_clk_i = 1'b0, ser_in_i = 1'b0;
   logic        ser_out_o;
   logic [31:0] cap_left_i = '0, cap_right_i = '0;
   logic        cap_valid_i = 1'b0;
   logic [31:0] pb_left_o, pb_right_o;
   logic        pb_valid_o;

   int checks = 0, failures = 0, vcount = 0;
   int g_fmt, g_w, g_pol, g_inv;
   bit g_noise;
   logic [31:0] g_pl, g_pr, g_cl, g_cr;

   always #10 clk = ~clk;

   audio_serial_port i_audio_serial_port (
      .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .wlen_i(wlen_i),
      .lr_pol_i(lr_pol_i), .bit_clk_inv_i(bit_clk_inv_i), .swap_i(swap_i),
      .bit_clk_i(bit_clk_i), .frame_clk_i(frame_clk_i), .ser_in_i(ser_in_i),
      .ser_out_o(ser_out_o), .cap_left_i(cap_left_i), .cap_right_i(cap_right_i),
      .cap_valid_i(cap_valid_i), .pb_left_o(pb_left_o), .pb_right_o(pb_right_o),
      .pb_valid_o(pb_valid_o));

   always @(negedge clk) if (pb_valid_o) vcount++;

   initial begin
      #(20.0 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] trunc(logic [31:0] w);
      return (g_w == 32) ? w : (w & ((32'd1 << g_w) - 32'd1));
   endfunction

   function automatic int frame_lvl(int i);
      int lvl;
      if (g_fmt == 3) return (i == 0) ? 1 : 0;
      lvl = (i < S) ? ((g_fmt == 2) ? 0 : 1) : ((g_fmt == 2) ? 1 : 0);
      return lvl ^ g_pol;
   endfunction

   // -1 means no word bit at this bit clock
   function automatic int slot_bit(int i, logic [31:0] l, logic [31:0] r);
      int fl, h, j, k, o;
      logic [31:0] w;
      fl = 2 * S;
      case (g_fmt)
         0: begin
            h = i / S; j = i % S; w = h ? r : l;
            if (j >= S - g_w) return int'(w[S-1-j]);
            return -1;
         end
         1: begin
            h = i / S; j = i % S; w = h ? r : l;
            if (j < g_w) return int'(w[g_w-1-j]);
            return -1;
         end
         2: begin
            k = (i + fl - 1) % fl; h = k / S; j = k % S; w = h ? r : l;
            if (j < g_w) return int'(w[g_w-1-j]);
            return -1;
         end
         default: begin
            o = g_pol ? 0 : 1;
            k = (i - o + fl) % fl;
            if (k < g_w) return int'(l[g_w-1-k]);
            if (k < 2 * g_w) return int'(r[2*g_w-1-k]);
            return -1;
         end
      endcase
   endfunction

   task automatic bit_period(int i, bit check, ref int mism, ref int first_i);
      int sb, e;
      logic expb;
      sb = slot_bit(i, g_pl, g_pr);
      bit_clk_i   = 1'b0 ^ g_inv[0];
      frame_clk_i = frame_lvl(i) != 0;
      ser_in_i    = (sb < 0) ? g_noise : sb[0];
      repeat (HALF) @(negedge clk);
      e = slot_bit(i, g_cl, g_cr);
      expb = (e < 0) ? 1'b0 : e[0];
      if (check && ser_out_o !== expb) begin
         if (mism == 0) first_i = i;
         mism++;
      end
      bit_clk_i = 1'b1 ^ g_inv[0];
      repeat (HALF) @(negedge clk);
   endtask

   task automatic run_case(string tag, int f, int wcode, int pol, int inv, int sw,
                           logic [31:0] pl, logic [31:0] pr,
                           logic [31:0] cl, logic [31:0] cr, bit load, bit noise);
      int mism = 0, first_i = -1, v0;
      logic [31:0] el, er;
      g_fmt = f; g_pol = pol; g_inv = inv; g_noise = noise;
      g_w = (wcode == 0) ? 16 : (wcode == 1) ? 20 : (wcode == 2) ? 24 : 32;
      g_pl = pl; g_pr = pr;
      @(negedge clk);
      fmt_i = 2'(f); wlen_i = 2'(wcode); lr_pol_i = pol[0];
      bit_clk_inv_i = inv[0]; swap_i = sw[0];
      if (load) begin
         g_cl = cl; g_cr = cr;
         cap_left_i = cl; cap_right_i = cr; cap_valid_i = 1'b1;
         @(negedge clk);
         cap_valid_i = 1'b0;
      end else begin
         cap_left_i = cl; cap_right_i = cr;
      end
      for (int fr = 0; fr < 3; fr++) begin
         if (fr == 2) v0 = vcount;
         for (int i = 0; i < 2 * S; i++) bit_period(i, fr == 2, mism, first_i);
      end
      checks++;
      if (mism != 0) begin
         failures++;
         $display("FAIL %s serial capture: %0d bad bits, first at %0d, actual mismatches=%0d expected=0",
                  tag, mism, first_i, mism);
      end
      chk({tag, " valid once per frame R11"}, 32'(vcount - v0), 32'd1);
      el = sw ? trunc(pr) : trunc(pl);
      er = sw ? trunc(pl) : trunc(pr);
      chk({tag, " left word"}, pb_left_o, el);
      chk({tag, " right word"}, pb_right_o, er);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      chk("R1 reset ser_out", 32'(ser_out_o), 32'd0);
      chk("R1 reset valid", 32'(pb_valid_o), 32'd0);
      chk("R1 reset left", pb_left_o, 32'd0);
      chk("R1 reset right", pb_right_o, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 after release ser_out", 32'(ser_out_o), 32'd0);

      run_case("R2 i2s w24", 2, 2, 0, 0, 0, 32'h00A5_3C71, 32'h005A_C38E,
               32'h0012_3456, 32'h00FE_DCBA, 1, 0);
      run_case("R3 lj w16", 1, 0, 0, 0, 0, 32'h0000_B00C, 32'h0000_4AF1,
               32'h0000_9137, 32'h0000_66E2, 1, 0);
      run_case("R4 rj w20", 0, 1, 0, 0, 0, 32'h000C_1D2E, 32'h0003_F0A5,
               32'h000A_5A5A, 32'h0005_1234, 1, 0);
      run_case("R4 rj w32", 0, 3, 0, 0, 0, 32'hDEAD_BEEF, 32'h1357_9BDF,
               32'h8001_7FFE, 32'hC0FF_EE00, 1, 0);
      run_case("R5 lj w32", 1, 3, 0, 0, 0, 32'hF00D_CAFE, 32'h0BAD_F00D,
               32'h7654_3210, 32'h89AB_CDEF, 1, 0);
      run_case("R5 i2s w20", 2, 1, 0, 0, 0, 32'h000F_1234, 32'h0008_8888,
               32'h0007_0F0F, 32'h000C_3C3C, 1, 0);
      run_case("R6 lj inverted frame clock", 1, 2, 1, 0, 0, 32'h00C3_5A81,
               32'h0042_0F0F, 32'h0099_1177, 32'h00AB_CDEF, 1, 0);
      run_case("R6 i2s inverted frame clock", 2, 0, 1, 0, 0, 32'h0000_8421,
               32'h0000_1248, 32'h0000_F731, 32'h0000_0E0E, 1, 0);
      run_case("R7 dsp submode1 w16", 3, 0, 0, 0, 0, 32'h0000_A1B2,
               32'h0000_C3D4, 32'h0000_5E6F, 32'h0000_7081, 1, 0);
      run_case("R7 dsp submode2 w32", 3, 3, 1, 0, 0, 32'h8765_4321,
               32'h0FED_CBA9, 32'hA5A5_5A5A, 32'h3C3C_C3C3, 1, 0);
      run_case("R8 i2s inverted bit clock", 2, 2, 0, 1, 0, 32'h0033_CC33,
               32'h00E1_E1E1, 32'h0019_7531, 32'h0086_4200, 1, 0);
      run_case("R8 dsp inverted bit clock", 3, 1, 1, 1, 0, 32'h000A_BCDE,
               32'h0001_2345, 32'h0009_8765, 32'h0004_3210, 1, 0);
      run_case("R9 lj swapped", 1, 2, 0, 0, 1, 32'h0011_2233, 32'h0044_5566,
               32'h0077_8899, 32'h00AA_BBCC, 1, 0);
      run_case("R10 rj noise and wide capture", 0, 0, 0, 0, 0, 32'h0000_6D2B,
               32'h0000_93C1, 32'hFFFF_1A2B, 32'hFFFF_3C4D, 1, 1);
      run_case("R10 i2s noise", 2, 0, 0, 0, 0, 32'h0000_0F1E,
               32'h0000_E1F0, 32'hABCD_5555, 32'h1234_AAAA, 1, 1);
      run_case("R12 no strobe keeps stored pair", 1, 0, 0, 0, 0, 32'h0000_2468,
               32'h0000_1357, 32'h0000_FFFF, 32'h0000_0000, 0, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule